// File: doc/BRIEF.md
# Processor Bus Cycle Strobe Decoder

This block connects a processor's time-multiplexed 16-bit information bus to external memory and I/O devices. A bus cycle opens when the active-high address strobe is raised. While the strobe is high, the bus word goes into an address latch, together with a memory/I/O qualifier and a read/write indication. A data phase follows. While it lasts, exactly one of four active-low strobes is asserted: memory read, memory write, I/O read or I/O write. The choice comes from the qualifiers captured with the address.

Two fixed I/O addresses have strobes of their own. An I/O write to 0x1000 also pulls the interrupt-acknowledge output low. An I/O read from 0x8410 also pulls the configuration-read output low. A two-bit control register sits at I/O address 0x8420 and can be read back over the bus. When the active-low strobe-enable input is high, its bits let the address outputs and the four cycle strobes be released to high impedance. The block generates an odd-parity bit on writes and checks parity on reads.

Every pin that can float is presented as a data/enable pair, and the pad ring builds the three-state buffer. All inputs are sampled on the rising edge of `clk`. The sequencer has four states:
- `ST_IDLE`: no cycle is in progress.
- `ST_LATCH`: the address strobe is high and the address is being captured.
- `ST_ARMED`: the address is held and the block waits for the data strobe.
- `ST_ACTIVE`: the data phase, during which a cycle strobe is asserted.

Transitions:
- IDLE→LATCH when the address strobe is high.
- LATCH→ARMED when it falls.
- ARMED→LATCH when a new address strobe arrives (abort).
- ARMED→ACTIVE when the data strobe is low.
- ACTIVE→IDLE when the data strobe returns high.

Top module: `bus_strobe_decoder`

## Requirements
- R1: After reset, all six active-low strobes are high, `addr_o` is 0, `addr_oe` and `strb_oe` are 1, and `bus_oe`, `par_oe` and `par_err` are 0.
- R2: On every clock edge where `addr_stb` is high, outside a data phase, `bus_i` is captured into `addr_o`. `addr_o` changes at no other time, whatever `bus_i` does.
- R3: The edge that samples `data_stb_n` low in ARMED makes exactly one strobe low. With `cyc_io`/`cyc_wr` captured as 0/0 it is `mem_rd_n`, 0/1 gives `mem_wr_n`, 1/0 gives `io_rd_n` and 1/1 gives `io_wr_n`.
- R4: The strobe returns high on the edge that samples `data_stb_n` high. Outside a data phase, all four cycle strobes are high.
- R5: `int_ack_n` is low during the data phase of an I/O write to address 0x1000, and at no other time.
- R6: `cfg_rd_n` is low during the data phase of an I/O read from address 0x8410, and at no other time.
- R7: An I/O write to 0x8420 stores `bus_i[1:0]` into the control register. Bit 0 is the address-float enable and bit 1 is the strobe-float enable. The value is taken on the edge that enters the data phase.
- R8: `addr_oe` is 0 only when `strobe_en_n` is 1 and control bit 0 is set. `strb_oe` is 0 only when `strobe_en_n` is 1 and control bit 1 is set.
- R9: During a write data phase, `par_oe` is 1 and `par_o` makes the count of ones in {`bus_i`,`par_o`} odd. Otherwise `par_oe` is 0.
- R10: A read is any read except an I/O read of 0x8420. On the edge that enters its data phase, `par_err` is set if {`bus_i`,`par_i`} holds an even number of ones, and cleared otherwise. It is cleared on the next address capture.
- R11: An address strobe seen in ARMED aborts the cycle. The new address is captured and no strobe is asserted until a later data phase.
- R12: `bus_oe` is 1 only during the data phase of an I/O read from 0x8420. During that phase `bus_o` carries the control register in bits [1:0], with zeros above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_stb | input | 1 | Address strobe, active high |
| data_stb_n | input | 1 | Data strobe, active low |
| cyc_io | input | 1 | Cycle qualifier: 1 = I/O, 0 = memory |
| cyc_wr | input | 1 | Direction: 1 = write, 0 = read |
| strobe_en_n | input | 1 | Output enable, active low; high allows floating |
| bus_i | input | 16 | Information bus, inward |
| bus_o | output | 16 | Information bus, outward data |
| bus_oe | output | 1 | Information bus drive enable |
| par_i | input | 1 | Parity line, inward |
| par_o | output | 1 | Parity line, generated bit |
| par_oe | output | 1 | Parity line drive enable |
| addr_o | output | 16 | Latched address |
| addr_oe | output | 1 | Address output enable |
| mem_rd_n | output | 1 | Memory read strobe |
| mem_wr_n | output | 1 | Memory write strobe |
| io_rd_n | output | 1 | I/O read strobe |
| io_wr_n | output | 1 | I/O write strobe |
| strb_oe | output | 1 | Enable for the four cycle strobes |
| int_ack_n | output | 1 | Interrupt acknowledge strobe |
| cfg_rd_n | output | 1 | Configuration-read strobe |
| par_err | output | 1 | Read parity error flag |

## Verification
Within one data phase, strobe decoding coincides with parity handling and with the special decodes. An I/O write to 0x1000 must drop `io_wr_n` and `int_ack_n` together while `par_oe` drives an odd-parity bit. A sweep covers every pairing of qualifier, direction and notable address, with deliberately good and bad read parity. In each data phase the bench compares the strobe vector, the special strobes, the parity outputs and the error flag against values it computes from the inputs. The float enables are also toggled during an active write to the control register itself, and the bench checks that `addr_oe`/`strb_oe` follow the newly stored bits.

// File: rtl/bsd_pkg.sv
package bsd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LATCH,
        ST_ARMED,
        ST_ACTIVE
    } bsd_state_e;

    typedef struct packed {
        logic io;
        logic wr;
    } cyc_kind_t;
endpackage

// File: rtl/bsd_seq.sv
module bsd_seq
    import bsd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic addr_stb,
    input  logic data_stb_n,
    output logic latch_en,
    output logic enter_active,
    output logic data_phase
);
    bsd_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (addr_stb) state_d = ST_LATCH;
            ST_LATCH:  if (!addr_stb) state_d = ST_ARMED;
            ST_ARMED: begin
                if (addr_stb)         state_d = ST_LATCH;
                else if (!data_stb_n) state_d = ST_ACTIVE;
            end
            ST_ACTIVE: if (data_stb_n) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        latch_en     = addr_stb && (state_q != ST_ACTIVE);
        enter_active = (state_q == ST_ARMED) && !addr_stb && !data_stb_n;
        data_phase   = (state_q == ST_ACTIVE);
    end
endmodule

// File: rtl/bsd_addr_latch.sv
module bsd_addr_latch
    import bsd_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          latch_en,
    input  logic [DW-1:0] bus_i,
    input  logic          io_i,
    input  logic          wr_i,
    output logic [DW-1:0] addr_q,
    output cyc_kind_t     kind_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            kind_q <= '0;
        end else if (latch_en) begin
            addr_q    <= bus_i;
            kind_q.io <= io_i;
            kind_q.wr <= wr_i;
        end
    end
endmodule

// File: rtl/bsd_parity.sv
module bsd_parity #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          sample,
    input  logic [DW-1:0] data_i,
    input  logic          par_i,
    output logic          par_gen,
    output logic          err_q
);
    // odd parity: generated bit makes total ones odd
    assign par_gen = ~^data_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      err_q <= 1'b0;
        else if (clear)  err_q <= 1'b0;
        else if (sample) err_q <= ~^{data_i, par_i};
    end
endmodule

// File: rtl/bus_strobe_decoder.sv
module bus_strobe_decoder
    import bsd_pkg::*;
#(
    parameter int          DW        = 16,
    parameter logic [15:0] INTA_ADDR = 16'h1000,
    parameter logic [15:0] CFG_ADDR  = 16'h8410,
    parameter logic [15:0] CTRL_ADDR = 16'h8420
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr_stb,
    input  logic          data_stb_n,
    input  logic          cyc_io,
    input  logic          cyc_wr,
    input  logic          strobe_en_n,
    input  logic [DW-1:0] bus_i,
    output logic [DW-1:0] bus_o,
    output logic          bus_oe,
    input  logic          par_i,
    output logic          par_o,
    output logic          par_oe,
    output logic [DW-1:0] addr_o,
    output logic          addr_oe,
    output logic          mem_rd_n,
    output logic          mem_wr_n,
    output logic          io_rd_n,
    output logic          io_wr_n,
    output logic          strb_oe,
    output logic          int_ack_n,
    output logic          cfg_rd_n,
    output logic          par_err
);
    localparam int CW = 2;
    localparam logic [DW-1:0] INTA_A = DW'(INTA_ADDR);
    localparam logic [DW-1:0] CFG_A  = DW'(CFG_ADDR);
    localparam logic [DW-1:0] CTRL_A = DW'(CTRL_ADDR);

    logic      latch_en, enter_active, data_phase;
    cyc_kind_t kind_q;
    logic [CW-1:0] ctrl_q;
    logic      hit_ctrl, hit_inta, hit_cfg, par_sample;

    bsd_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr_stb     (addr_stb),
        .data_stb_n   (data_stb_n),
        .latch_en     (latch_en),
        .enter_active (enter_active),
        .data_phase   (data_phase)
    );

    bsd_addr_latch #(.DW(DW)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .latch_en (latch_en),
        .bus_i    (bus_i),
        .io_i     (cyc_io),
        .wr_i     (cyc_wr),
        .addr_q   (addr_o),
        .kind_q   (kind_q)
    );

    assign hit_ctrl   = kind_q.io && (addr_o == CTRL_A);
    assign hit_inta   = kind_q.io && (addr_o == INTA_A);
    assign hit_cfg    = kind_q.io && (addr_o == CFG_A);
    assign par_sample = enter_active && !kind_q.wr && !hit_ctrl;

    bsd_parity #(.DW(DW)) u_par (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (latch_en),
        .sample  (par_sample),
        .data_i  (bus_i),
        .par_i   (par_i),
        .par_gen (par_o),
        .err_q   (par_err)
    );

    // float-enable register: bit0 address, bit1 strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (enter_active && hit_ctrl && kind_q.wr)
            ctrl_q <= bus_i[CW-1:0];
    end

    always_comb begin
        mem_rd_n  = !(data_phase && !kind_q.io && !kind_q.wr);
        mem_wr_n  = !(data_phase && !kind_q.io &&  kind_q.wr);
        io_rd_n   = !(data_phase &&  kind_q.io && !kind_q.wr);
        io_wr_n   = !(data_phase &&  kind_q.io &&  kind_q.wr);
        int_ack_n = !(data_phase && hit_inta && kind_q.wr);
        cfg_rd_n  = !(data_phase && hit_cfg && !kind_q.wr);
        bus_oe    = data_phase && hit_ctrl && !kind_q.wr;
        bus_o     = {{(DW-CW){1'b0}}, ctrl_q};
        par_oe    = data_phase && kind_q.wr;
        addr_oe   = !(strobe_en_n && ctrl_q[0]);
        strb_oe   = !(strobe_en_n && ctrl_q[1]);
    end
endmodule

// File: rtl/bus_strobe_decoder_chk.sv
module bus_strobe_decoder_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          addr_stb,
    input logic          data_stb_n,
    input logic          strobe_en_n,
    input logic          bus_oe,
    input logic          par_oe,
    input logic [DW-1:0] addr_o,
    input logic          addr_oe,
    input logic          mem_rd_n,
    input logic          mem_wr_n,
    input logic          io_rd_n,
    input logic          io_wr_n,
    input logic          strb_oe,
    input logic          int_ack_n,
    input logic          cfg_rd_n
);
    logic any_strb;
    assign any_strb = !(mem_rd_n && mem_wr_n && io_rd_n && io_wr_n);

    a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({!mem_rd_n, !mem_wr_n, !io_rd_n, !io_wr_n}) <= 1);

    a_r3_start_on_ds: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(any_strb) |-> $past(!data_stb_n));

    a_r4_end_on_ds: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(any_strb) |-> $past(data_stb_n));

    a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_o != $past(addr_o)) |-> $past(addr_stb));

    a_r5_inta_with_iow: assert property (@(posedge clk) disable iff (!rst_n)
        !int_ack_n |-> !io_wr_n);

    a_r6_cfg_with_ior: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rd_n |-> !io_rd_n);

    a_r8_driven_when_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_en_n |-> (addr_oe && strb_oe));

    a_r9_par_only_writes: assert property (@(posedge clk) disable iff (!rst_n)
        par_oe |-> (!mem_wr_n || !io_wr_n));

    a_r12_bus_only_ior: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> !io_rd_n);
endmodule

bind bus_strobe_decoder bus_strobe_decoder_chk #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_stb    (addr_stb),
    .data_stb_n  (data_stb_n),
    .strobe_en_n (strobe_en_n),
    .bus_oe      (bus_oe),
    .par_oe      (par_oe),
    .addr_o      (addr_o),
    .addr_oe     (addr_oe),
    .mem_rd_n    (mem_rd_n),
    .mem_wr_n    (mem_wr_n),
    .io_rd_n     (io_rd_n),
    .io_wr_n     (io_wr_n),
    .strb_oe     (strb_oe),
    .int_ack_n   (int_ack_n),
    .cfg_rd_n    (cfg_rd_n)
);

// File: tb/bus_strobe_decoder_test.sv
module bus_strobe_decoder_test;
    logic clk = 0, rst_n = 0;
    logic addr_stb = 0, data_stb_n = 1, cyc_io = 0, cyc_wr = 0, strobe_en_n = 0;
    logic [15:0] bus_i = 0, bus_o, addr_o;
    logic par_i = 0, par_o, par_oe, bus_oe, addr_oe, strb_oe;
    logic mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, int_ack_n, cfg_rd_n, par_err;

    int checks = 0, failures = 0;
    bit done = 0;
    logic [1:0] ctrl_exp = 0;

    always #10 clk = ~clk;

    bus_strobe_decoder uut (
        .clk(clk), .rst_n(rst_n), .addr_stb(addr_stb), .data_stb_n(data_stb_n),
        .cyc_io(cyc_io), .cyc_wr(cyc_wr), .strobe_en_n(strobe_en_n),
        .bus_i(bus_i), .bus_o(bus_o), .bus_oe(bus_oe), .par_i(par_i),
        .par_o(par_o), .par_oe(par_oe), .addr_o(addr_o), .addr_oe(addr_oe),
        .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n),
        .io_wr_n(io_wr_n), .strb_oe(strb_oe), .int_ack_n(int_ack_n),
        .cfg_rd_n(cfg_rd_n), .par_err(par_err)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] strobes();
        return {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n};
    endfunction

    // full bus cycle; checks taken in the data phase and after it
    task automatic bus_cycle(input logic [15:0] a, input bit io, input bit wr,
                             input logic [15:0] d, input bit p);
        logic [3:0] exp_s;
        bit ctrl_rd;
        @(negedge clk);
        addr_stb = 1; bus_i = a; cyc_io = io; cyc_wr = wr;
        @(negedge clk);
        check("R2 capture", 32'(addr_o), 32'(a));
        check("R10 clear on capture", 32'(par_err), 0);
        addr_stb = 0; bus_i = d; par_i = p; cyc_io = ~io; cyc_wr = ~wr;
        @(negedge clk);
        check("R4 idle before data", 32'(strobes()), 32'hF);
        data_stb_n = 0;
        @(negedge clk);
        exp_s = ~(4'b1000 >> {io, wr});
        ctrl_rd = io && !wr && (a == 16'h8420);
        if (io && wr && a == 16'h8420) ctrl_exp = d[1:0];
        check("R3 strobe select", 32'(strobes()), 32'(exp_s));
        check("R2 hold", 32'(addr_o), 32'(a));
        check("R5 int ack", 32'(int_ack_n), 32'(!(io && wr && a == 16'h1000)));
        check("R6 cfg read", 32'(cfg_rd_n), 32'(!(io && !wr && a == 16'h8410)));
        check("R9 par_oe", 32'(par_oe), 32'(wr));
        if (wr) check("R9 odd parity", 32'(^{d, par_o}), 1);
        check("R10 par_err", 32'(par_err), 32'((!wr && !ctrl_rd) ? ~^{d, p} : 1'b0));
        check("R12 bus_oe", 32'(bus_oe), 32'(ctrl_rd));
        if (ctrl_rd) check("R7 readback", 32'(bus_o), 32'(ctrl_exp));
        data_stb_n = 1;
        @(negedge clk);
        check("R4 release", 32'({strobes(), int_ack_n, cfg_rd_n}), 32'h3F);
        check("R12 bus_oe off", 32'(bus_oe), 0);
    endtask

    initial begin
        logic [15:0] addrs [6];
        logic [15:0] d;
        addrs = '{16'h0000, 16'h1000, 16'h8410, 16'h8420, 16'hFFFF, 16'h5A5A};
        repeat (3) @(negedge clk);
        check("R1 strobes", 32'({strobes(), int_ack_n, cfg_rd_n}), 32'h3F);
        check("R1 addr", 32'(addr_o), 0);
        check("R1 oe", 32'({addr_oe, strb_oe, bus_oe, par_oe, par_err}), 32'b11000);
        rst_n = 1;

        // sweep: qualifier x direction x address x parity
        for (int i = 0; i < 6; i++)
            for (int k = 0; k < 4; k++)
                for (int p = 0; p < 2; p++) begin
                    d = 16'h3C00 ^ (16'(i) * 16'h1111) ^ 16'(k << 4) ^ 16'(p);
                    bus_cycle(addrs[i], k[1], k[0], d, p[0]);
                end

        // R11 abort: second address strobe while armed
        @(negedge clk); addr_stb = 1; bus_i = 16'h1000; cyc_io = 1; cyc_wr = 1;
        @(negedge clk); addr_stb = 0;
        @(negedge clk); addr_stb = 1; bus_i = 16'h0042; cyc_io = 0; cyc_wr = 0;
        data_stb_n = 0;
        @(negedge clk);
        check("R11 no strobe on abort", 32'({strobes(), int_ack_n}), 32'h1F);
        check("R11 new address", 32'(addr_o), 32'h0042);
        addr_stb = 0;
        @(negedge clk);
        check("R11 still armed", 32'(strobes()), 32'hF);
        @(negedge clk);
        check("R11 later data phase", 32'(strobes()), 32'b0111);
        data_stb_n = 1;
        @(negedge clk);

        // R7/R8 float control across all register values
        for (int v = 0; v < 4; v++) begin
            bus_cycle(16'h8420, 1, 1, 16'(v) | 16'hA5A4, 1'b0);
            check("R7 stored", 32'(ctrl_exp), 32'(v));
            bus_cycle(16'h8420, 1, 0, 16'h0000, 1'b0);
            strobe_en_n = 0;
            @(negedge clk);
            check("R8 enabled drive", 32'({addr_oe, strb_oe}), 32'b11);
            strobe_en_n = 1;
            @(negedge clk);
            check("R8 addr float", 32'(addr_oe), 32'(!v[0]));
            check("R8 strobe float", 32'(strb_oe), 32'(!v[1]));
        end
        // register write while floated still works
        bus_cycle(16'h8420, 1, 1, 16'h0000, 1'b0);
        check("R8 unfloat", 32'({addr_oe, strb_oe}), 32'b11);
        strobe_en_n = 0;

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R4 watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule